// File: doc/BRIEF.md
# Target-Time Periodic Pulse Generator

This block produces a square wave on an output pin whose first transition is tied to an absolute value of the running system time. Software loads a 64-bit start time and a 64-bit half-period through 32-bit word writes, then sets the enable bit. Once the system time input reaches or passes the start time, the pin level flips. The next flip is then scheduled at the previous scheduled time plus the half-period. All times are in the raw fixed-point units of the time counter. If software loads the half-period with one second scaled into counter units and the start time with the next whole-second boundary, the output becomes a one-pulse-per-second source.

Each level flip can raise a one-cycle interrupt request. This request is gated by an interrupt-enable bit in the control word and by a mask that two strobes set and clear. The pin is driven only when the pad is configured as an output and routed to this function. If either condition is missing, the output and its output enable are both held low, but the schedule keeps running.

Top module: `tt_pulse_gen`

## Requirements
- R1: After reset the generator is disabled, the internal pin level is low, `irq_o` is low and the interrupt is masked.
- R2: Writes use `wr_addr_i`. Address 0 is the start time bits 31:0 and address 1 is bits 63:32. Address 2 is the half-period bits 31:0 and address 3 is bits 63:32. Address 4 is the control word, with bit 0 = enable, bit 1 = start-on-target mode and bit 2 = interrupt enable. Writes to addresses 5 to 7 are ignored.
- R3: In start-on-target mode the first level flip occurs at the first clock edge that samples `sys_time_i` greater than or equal to the start time. This applies from the second cycle after the enabling write.
- R4: After every flip, the next flip time equals the previous scheduled flip time plus the half-period, modulo 2^64.
- R5: The level never changes while enabled and `sys_time_i` is below the scheduled time. A time input that advances by more than one unit per cycle flips on the first sample at or past the scheduled time.
- R6: With start-on-target mode off, the first flip is scheduled at the `sys_time_i` value seen in the cycle after the enabling write, plus the half-period.
- R7: Writing the control word with enable = 0 returns the level to low within two cycles and stops all flips. Re-enabling always starts from a low level.
- R8: While disabled, the schedule follows the start-time register, so reprogramming it restarts the sequence at the new value. A start-time write while enabled does not change the running schedule.
- R9: A half-period write while running is used at the next flip to compute the following flip time.
- R10: `irq_o` pulses for one cycle, in the cycle the level has just flipped, only when interrupt enable is 1 and the mask is open. `irq_unmask_i` opens the mask and `irq_mask_i` closes it. If both are asserted in the same cycle, the mask closes.
- R11: `pin_oe_o` is high only when both `pin_dir_out_i` and `pin_native_i` are high. `pin_o` shows the level only then, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_time_i | input | 64 | Running system time in counter units |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Register write data |
| irq_unmask_i | input | 1 | Opens the interrupt mask |
| irq_mask_i | input | 1 | Closes the interrupt mask |
| pin_dir_out_i | input | 1 | Pad configured as output |
| pin_native_i | input | 1 | Pad routed to this function |
| pin_o | output | 1 | Pin level |
| pin_oe_o | output | 1 | Pin output enable |
| irq_o | output | 1 | Interrupt request, one pulse per level flip |

## Verification
The properties assume that `sys_time_i` increases monotonically while the generator is enabled. They also assume that it never wraps past 2^64 between a scheduled time and its match, since a wrapped time would look earlier than the schedule. The stimulus keeps these assumptions in two ways. It advances time by a fixed positive step each cycle, and it performs its one large forward jump of the time base only while the generator is disabled. Every start time is placed ahead of the current time at the moment of enabling, so that each observed flip can be tied to one scheduled value.

// File: rtl/ttpg_pkg.sv
package ttpg_pkg;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_SYNC_BIT = 1;
  localparam int unsigned CTRL_IRQ_BIT  = 2;

  typedef struct packed {
    logic irq_en;
    logic sync;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/ttpg_regs.sv
module ttpg_regs
  import ttpg_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [TIME_W-1:0] target_o,
  output logic [TIME_W-1:0] period_o,
  output ctrl_t             ctrl_o,
  output logic              arm_o
);
  localparam int unsigned NWORDS    = TIME_W / WORD_W;
  localparam int unsigned CTRL_ADDR = 2 * NWORDS;

  logic [TIME_W-1:0] target_q, period_q;
  ctrl_t             ctrl_q;
  logic              arm_q;
  logic              ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      period_q <= '0;
    end else if (wr_en_i) begin
      for (int w = 0; w < int'(NWORDS); w++) begin
        if (wr_addr_i == ADDR_W'(w))
          target_q[w*WORD_W +: WORD_W] <= wr_data_i;
        if (wr_addr_i == ADDR_W'(NWORDS + w))
          period_q[w*WORD_W +: WORD_W] <= wr_data_i;
      end
    end
  end

  // arm pulses the cycle after a disabled->enabled control write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      arm_q <= ctrl_wr && wr_data_i[CTRL_EN_BIT] && !ctrl_q.en;
      if (ctrl_wr) begin
        ctrl_q.en     <= wr_data_i[CTRL_EN_BIT];
        ctrl_q.sync   <= wr_data_i[CTRL_SYNC_BIT];
        ctrl_q.irq_en <= wr_data_i[CTRL_IRQ_BIT];
      end
    end
  end

  assign target_o = target_q;
  assign period_o = period_q;
  assign ctrl_o   = ctrl_q;
  assign arm_o    = arm_q;
endmodule

// File: rtl/ttpg_sched.sv
module ttpg_sched #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_i,
  input  logic              arm_i,
  input  logic [TIME_W-1:0] sys_time_i,
  input  logic [TIME_W-1:0] target_i,
  input  logic [TIME_W-1:0] period_i,
  output logic [TIME_W-1:0] next_edge_o,
  output logic              level_o,
  output logic              flip_o
);
  logic [TIME_W-1:0] next_q;
  logic              level_q;
  logic              reached;

  // magnitude compare so coarse time steps cannot skip the match
  assign reached = (sys_time_i >= next_q);
  assign flip_o  = en_i && !arm_i && reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q  <= '0;
      level_q <= 1'b0;
    end else if (!en_i) begin
      next_q  <= target_i;
      level_q <= 1'b0;
    end else if (arm_i) begin
      next_q <= sync_i ? target_i : sys_time_i + period_i;
    end else if (reached) begin
      next_q  <= next_q + period_i;
      level_q <= ~level_q;
    end
  end

  assign next_edge_o = next_q;
  assign level_o     = level_q;
endmodule

// File: rtl/ttpg_irq.sv
module ttpg_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flip_i,
  input  logic irq_en_i,
  input  logic unmask_i,
  input  logic mask_i,
  output logic unmasked_o,
  output logic irq_o
);
  logic open_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_i)        open_q <= 1'b0;
      else if (unmask_i) open_q <= 1'b1;
      irq_q <= flip_i && irq_en_i && open_q;
    end
  end

  assign unmasked_o = open_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/tt_pulse_gen.sv
module tt_pulse_gen
  import ttpg_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = $clog2(2 * (TIME_W / WORD_W) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] sys_time_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              irq_unmask_i,
  input  logic              irq_mask_i,
  input  logic              pin_dir_out_i,
  input  logic              pin_native_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              irq_o
);
  logic [TIME_W-1:0] target, period, next_edge;
  ctrl_t             ctrl;
  logic              arm, level, flip, unmasked;

  ttpg_regs #(.TIME_W(TIME_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .target_o  (target),
    .period_o  (period),
    .ctrl_o    (ctrl),
    .arm_o     (arm)
  );

  ttpg_sched #(.TIME_W(TIME_W)) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl.en),
    .sync_i      (ctrl.sync),
    .arm_i       (arm),
    .sys_time_i  (sys_time_i),
    .target_i    (target),
    .period_i    (period),
    .next_edge_o (next_edge),
    .level_o     (level),
    .flip_o      (flip)
  );

  ttpg_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flip_i     (flip),
    .irq_en_i   (ctrl.irq_en),
    .unmask_i   (irq_unmask_i),
    .mask_i     (irq_mask_i),
    .unmasked_o (unmasked),
    .irq_o      (irq_o)
  );

  assign pin_oe_o = pin_dir_out_i && pin_native_i;
  assign pin_o    = pin_oe_o && level;
endmodule

// File: rtl/tt_pulse_gen_chk.sv
module tt_pulse_gen_chk #(
  parameter int unsigned TIME_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              level_i,
  input logic [TIME_W-1:0] next_edge_i,
  input logic [TIME_W-1:0] period_i,
  input logic [TIME_W-1:0] sys_time_i,
  input logic              unmasked_i,
  input logic              irq_i
);
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !level_i); // R7

  AST_IRQ_ON_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (level_i != $past(level_i))); // R10

  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unmasked_i |=> !irq_i); // R10

  AST_PERIOD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && (level_i != $past(level_i)))
      |-> (next_edge_i == $past(next_edge_i) + $past(period_i))); // R4

  AST_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (sys_time_i < next_edge_i)) |=> $stable(level_i)); // R5
endmodule

bind tt_pulse_gen tt_pulse_gen_chk #(.TIME_W(TIME_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (ctrl.en),
  .level_i     (level),
  .next_edge_i (next_edge),
  .period_i    (period),
  .sys_time_i  (sys_time_i),
  .unmasked_i  (unmasked),
  .irq_i       (irq_o)
);

// File: tb/tt_pulse_gen_test.sv
module tt_pulse_gen_test;
  localparam int unsigned TIME_W = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [TIME_W-1:0] sys_time;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic              irq_unmask, irq_mask, dir_out, native;
  logic              pin, pin_oe, irq;

  tt_pulse_gen #(.TIME_W(TIME_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sys_time_i(sys_time),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_unmask_i(irq_unmask), .irq_mask_i(irq_mask),
    .pin_dir_out_i(dir_out), .pin_native_i(native),
    .pin_o(pin), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] cur_t, step, wr_t;
  logic [63:0] edge_t [16];
  int n_edge, n_irq;
  logic last_pin;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (pin !== last_pin) begin
      if (n_edge < 16) edge_t[n_edge] = cur_t;
      n_edge++;
    end
    last_pin = pin;
    if (irq === 1'b1) n_irq++;
    cur_t = cur_t + step;
    sys_time = cur_t;
    wr_en = 1'b0;
    irq_mask = 1'b0;
    irq_unmask = 1'b0;
  endtask

  task automatic run_to(logic [63:0] t);
    while (cur_t < t) tick();
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_t = cur_t;
    tick();
  endtask

  task automatic set_target(logic [63:0] v);
    wr(3'd0, v[31:0]); wr(3'd1, v[63:32]);
  endtask

  task automatic set_period(logic [63:0] v);
    wr(3'd2, v[31:0]); wr(3'd3, v[63:32]);
  endtask

  task automatic clr_log();
    n_edge = 0; n_irq = 0;
  endtask

  task automatic disable_gen();
    wr(3'd4, 32'd0);
    repeat (3) tick();
    clr_log();
  endtask

  task automatic test_reset();
    chk("R1", "pin after reset", 64'(pin), 64'd0);
    chk("R1", "irq after reset", 64'(irq), 64'd0);
    chk("R11", "oe routed", 64'(pin_oe), 64'd1);
  endtask

  task automatic test_sync();
    logic [63:0] base;
    base = cur_t + 100;
    set_target(base);
    set_period(64'd50);
    irq_unmask = 1'b1; tick();
    clr_log();
    wr(3'd4, 32'h7);
    run_to(base + 160);
    chk("R3", "edge count", 64'(n_edge), 64'd4);
    chk("R3", "first edge at target", edge_t[0], base);
    chk("R4", "second edge", edge_t[1], base + 50);
    chk("R4", "third edge", edge_t[2], base + 100);
    chk("R4", "fourth edge", edge_t[3], base + 150);
    chk("R10", "irq per flip", 64'(n_irq), 64'd4);
    chk("R2", "level after even flips", 64'(pin), 64'd0);
    disable_gen();
  endtask

  task automatic test_disable_restart();
    logic [63:0] tgt;
    set_period(64'd30);
    tgt = cur_t + 30;
    set_target(tgt);
    clr_log();
    wr(3'd4, 32'h3);
    run_to(tgt + 8);
    chk("R3", "single edge", 64'(n_edge), 64'd1);
    chk("R7", "level high after first flip", 64'(pin), 64'd1);
    chk("R10", "no irq when disabled in ctrl", 64'(n_irq), 64'd0);
    native = 1'b0; #1;
    chk("R11", "pin low when not routed", 64'(pin), 64'd0);
    chk("R11", "oe low when not routed", 64'(pin_oe), 64'd0);
    native = 1'b1; #1;
    chk("R11", "pin back when routed", 64'(pin), 64'd1);
    wr(3'd4, 32'd0);
    repeat (3) tick();
    chk("R7", "level low after disable", 64'(pin), 64'd0);
    clr_log();
    run_to(cur_t + 100);
    chk("R7", "no flips while disabled", 64'(n_edge), 64'd0);
    wr(3'd5, 32'h7);
    wr(3'd7, 32'h7);
    run_to(cur_t + 50);
    chk("R2", "unmapped writes ignored", 64'(n_edge), 64'd0);
    set_target(cur_t + 400);
    tgt = cur_t + 30;
    set_target(tgt);
    clr_log();
    wr(3'd4, 32'h3);
    run_to(tgt + 10);
    chk("R8", "restart at new target", edge_t[0], tgt);
    chk("R8", "restart edge count", 64'(n_edge), 64'd1);
    chk("R7", "restart rises from low", 64'(pin), 64'd1);
    disable_gen();
  endtask

  task automatic test_live_update();
    logic [63:0] t0;
    set_period(64'd40);
    t0 = cur_t + 20;
    set_target(t0);
    clr_log();
    wr(3'd4, 32'h3);
    run_to(t0 + 1);
    set_target(cur_t + 5);
    set_period(64'd20);
    run_to(t0 + 70);
    chk("R8", "live edge count", 64'(n_edge), 64'd3);
    chk("R8", "first live edge", edge_t[0], t0);
    chk("R9", "old period used", edge_t[1], t0 + 40);
    chk("R9", "new period used", edge_t[2], t0 + 60);
    disable_gen();
  endtask

  task automatic test_jump();
    set_target(64'h1_0000_000A);
    set_period(64'd10);
    cur_t = 64'h0000_0000_FFFF_FFF0;
    sys_time = cur_t;
    step = 64'd7;
    clr_log();
    wr(3'd4, 32'h3);
    repeat (14) tick();
    chk("R5", "first coarse edge", edge_t[0], 64'h1_0000_000C);
    chk("R5", "second coarse edge", edge_t[1], 64'h1_0000_001A);
    chk("R2", "third edge high word", edge_t[2], 64'h1_0000_0021);
    step = 64'd1;
    disable_gen();
  endtask

  task automatic test_free_run();
    logic [63:0] tw;
    set_period(64'd25);
    clr_log();
    wr(3'd4, 32'h5);
    tw = wr_t;
    run_to(tw + 61);
    chk("R6", "edge count", 64'(n_edge), 64'd2);
    chk("R6", "first free edge", edge_t[0], tw + 26);
    chk("R6", "second free edge", edge_t[1], tw + 51);
    chk("R10", "irq per free edge", 64'(n_irq), 64'd2);
    irq_mask = 1'b1; tick();
    clr_log();
    run_to(tw + 80);
    chk("R10", "masked edge seen", 64'(n_edge), 64'd1);
    chk("R10", "masked no irq", 64'(n_irq), 64'd0);
    irq_mask = 1'b1; irq_unmask = 1'b1; tick();
    clr_log();
    run_to(tw + 105);
    chk("R10", "mask wins over unmask", 64'(n_irq), 64'd0);
    irq_unmask = 1'b1; tick();
    clr_log();
    run_to(tw + 130);
    chk("R10", "unmasked irq back", 64'(n_irq), 64'd1);
    disable_gen();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_t = '0; step = 64'd1; wr_t = '0;
    sys_time = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    irq_unmask = 1'b0; irq_mask = 1'b0; dir_out = 1'b1; native = 1'b1;
    last_pin = 1'b0; n_edge = 0; n_irq = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    test_reset();
    test_sync();
    test_disable_restart();
    test_live_update();
    test_jump();
    test_free_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule